// File: doc/BRIEF.md
# Slot-Timed Transmit Control State Machine

This block sequences one transmitter in a time-slotted radio. When a start request arrives, it waits in a pending state until the slot timing strobe marks the start point. It then enables the bit engine. When the engine reports that a message is complete, the block returns to idle if the transmit FIFO is empty. If the FIFO still holds data, it moves into a chained state and sends the next message straight away. Every completion produces a one-cycle interrupt pulse, and a sticky copy of that pulse stays set until status is read.

While listen-before-talk mode is enabled, a sensed carrier aborts any pending or active transmission and sends the machine back to idle without an interrupt. A control write carries two command bits. One bit forces the machine to idle. The other sends a one-cycle clear pulse to the FIFO. The modulator, the slot timer and the FIFO storage are outside this block.

Top module: `tx_slot_ctrl`

## Requirements
- R1: After asynchronous reset, state_o is 2'b00 (idle) and done_irq_o, done_sticky_o, fifo_clr_o and tx_en_o are 0.
- R2: In idle, start_i moves state_o to 2'b01 (pending) on the next cycle. start_i in any other state has no effect, so a repeated start while pending keeps 2'b01.
- R3: In pending, start_point_i moves state_o to 2'b10 (in progress). start_point_i in any other state has no effect. tx_en_o is 1 exactly while state_o is 2'b10 or 2'b11.
- R4: In pending, in progress or chained, cs_mode_i=1 together with carrier_i=1 returns state_o to 2'b00 without a done pulse. carrier_i with cs_mode_i=0 has no effect.
- R5: In 2'b10 or 2'b11, tx_done_i with fifo_empty_i=0 moves state_o to 2'b11 (chained) and raises done_irq_o.
- R6: In 2'b10 or 2'b11, tx_done_i with fifo_empty_i=1 moves state_o to 2'b00 and raises done_irq_o. tx_done_i in idle or pending has no effect.
- R7: A write (ctrl_we_i=1) with ctrl_d_i bit 0 set forces state_o to 2'b00. A write with ctrl_d_i bit 1 set makes fifo_clr_o 1 for exactly the next cycle. In every other cycle fifo_clr_o is 0.
- R8: done_irq_o is 1 only in the cycle after an accepted completion, and at that point state_o has already changed. done_sticky_o is set in the same cycle and is cleared by status_rd_i. If a new pulse and a read coincide, the bit stays set.
- R9: A soft reset (ctrl_we_i with bit 0 set) takes priority over start, start point, abort and completion in the same cycle, and it suppresses the done pulse.
- R10: An abort (R4) takes priority over a completion in the same cycle, so no done pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Transmit start request |
| start_point_i | input | 1 | Slot start point strobe |
| cs_mode_i | input | 1 | Listen-before-talk mode enable |
| carrier_i | input | 1 | Carrier sensed |
| tx_done_i | input | 1 | Bit engine message complete strobe |
| fifo_empty_i | input | 1 | Transmit FIFO empty flag |
| ctrl_we_i | input | 1 | Control command write strobe |
| ctrl_d_i | input | 2 | Command bits: bit 0 resets the FSM, bit 1 clears the FIFO |
| status_rd_i | input | 1 | Status read, clears the sticky done bit |
| state_o | output | 2 | State code: 00 idle, 01 pending, 10 in progress, 11 chained |
| done_irq_o | output | 1 | One-cycle done interrupt |
| done_sticky_o | output | 1 | Sticky done flag |
| fifo_clr_o | output | 1 | One-cycle FIFO clear |
| tx_en_o | output | 1 | Transmit enable to the bit engine |

## Verification
Directed sequences first walk through the legal path idle, pending, in progress, chained and back to idle. They also place the conflicting events in a single cycle: abort together with completion, soft reset together with start and completion, and a read together with a new done pulse. These cycles show which priority the logic actually applies. Random traffic then varies the start, strobe, carrier, completion and FIFO-empty inputs at independent rates. Repeated completions, ignored strobes in the wrong states and carrier with the mode off therefore show up in every state. A model that only handled single events cleanly would fail on this traffic.

// File: rtl/tx_slot_pkg.sv
package tx_slot_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_PEND  = 2'b01,
    ST_PROG  = 2'b10,
    ST_CHAIN = 2'b11
  } tx_state_e;
endpackage

// File: rtl/tx_slot_cmd.sv
module tx_slot_cmd #(
  parameter int CTRL_W  = 2,
  parameter int RST_BIT = 0,
  parameter int CLR_BIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_d_i,
  output logic              fsm_rst_o,
  output logic              fifo_clr_o
);
  logic clr_q;

  assign fsm_rst_o = ctrl_we_i & ctrl_d_i[RST_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clr_q <= 1'b0;
    else         clr_q <= ctrl_we_i & ctrl_d_i[CLR_BIT];
  end

  assign fifo_clr_o = clr_q;

  a_r7_clr_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_d_i[CLR_BIT]) |=> fifo_clr_o);
  a_r7_clr_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_we_i && ctrl_d_i[CLR_BIT]) |=> !fifo_clr_o);
endmodule

// File: rtl/tx_slot_fsm.sv
module tx_slot_fsm
  import tx_slot_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fsm_rst_i,
  input  logic       start_i,
  input  logic       start_point_i,
  input  logic       abort_i,
  input  logic       tx_done_i,
  input  logic       fifo_empty_i,
  output logic [1:0] state_o,
  output logic       done_evt_o,
  output logic       tx_en_o
);
  tx_state_e state_q, state_d;
  logic      active;

  assign active = (state_q == ST_PROG) || (state_q == ST_CHAIN);

  always_comb begin
    state_d    = state_q;
    done_evt_o = 1'b0;
    if (fsm_rst_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) state_d = ST_PEND;
        ST_PEND: begin
          if (abort_i)            state_d = ST_IDLE;
          else if (start_point_i) state_d = ST_PROG;
        end
        ST_PROG, ST_CHAIN: begin
          if (abort_i) begin
            state_d = ST_IDLE;
          end else if (tx_done_i) begin
            done_evt_o = 1'b1;
            state_d    = fifo_empty_i ? ST_IDLE : ST_CHAIN;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign tx_en_o = active;

  a_r2_idle_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && !fsm_rst_i) |=> state_q == ST_PEND);
  a_r3_pend_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PEND && start_point_i && !abort_i && !fsm_rst_i) |=> state_q == ST_PROG);
  a_r4_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && abort_i) |=> state_q == ST_IDLE);
  a_r5_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && tx_done_i && !fifo_empty_i && !abort_i && !fsm_rst_i) |=> state_q == ST_CHAIN);
  a_r9_soft_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsm_rst_i |=> state_q == ST_IDLE);
endmodule

// File: rtl/tx_slot_irq.sv
module tx_slot_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_evt_i,
  input  logic status_rd_i,
  output logic done_irq_o,
  output logic done_sticky_o
);
  logic irq_q, sticky_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q    <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      irq_q    <= done_evt_i;
      sticky_q <= done_evt_i | (sticky_q & ~status_rd_i);
    end
  end

  assign done_irq_o    = irq_q;
  assign done_sticky_o = sticky_q;

  a_r8_sticky_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_irq_o |-> done_sticky_o);
  a_r8_read_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_rd_i && !done_evt_i) |=> !done_sticky_o);
endmodule

// File: rtl/tx_slot_ctrl.sv
module tx_slot_ctrl #(
  parameter int CTRL_W  = 2,
  parameter int RST_BIT = 0,
  parameter int CLR_BIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              start_point_i,
  input  logic              cs_mode_i,
  input  logic              carrier_i,
  input  logic              tx_done_i,
  input  logic              fifo_empty_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_d_i,
  input  logic              status_rd_i,
  output logic [1:0]        state_o,
  output logic              done_irq_o,
  output logic              done_sticky_o,
  output logic              fifo_clr_o,
  output logic              tx_en_o
);
  logic fsm_rst, abort, done_evt;

  // carrier only counts when listen-before-talk is on
  assign abort = cs_mode_i & carrier_i;

  tx_slot_cmd #(.CTRL_W(CTRL_W), .RST_BIT(RST_BIT), .CLR_BIT(CLR_BIT)) u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_we_i  (ctrl_we_i),
    .ctrl_d_i   (ctrl_d_i),
    .fsm_rst_o  (fsm_rst),
    .fifo_clr_o (fifo_clr_o)
  );

  tx_slot_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fsm_rst_i     (fsm_rst),
    .start_i       (start_i),
    .start_point_i (start_point_i),
    .abort_i       (abort),
    .tx_done_i     (tx_done_i),
    .fifo_empty_i  (fifo_empty_i),
    .state_o       (state_o),
    .done_evt_o    (done_evt),
    .tx_en_o       (tx_en_o)
  );

  tx_slot_irq u_irq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .done_evt_i    (done_evt),
    .status_rd_i   (status_rd_i),
    .done_irq_o    (done_irq_o),
    .done_sticky_o (done_sticky_o)
  );

  a_r10_abort_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort && state_o != 2'b00) |=> !done_irq_o);
  a_r9_rst_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsm_rst |=> !done_irq_o);
  a_r3_tx_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_o |-> state_o[1]);
endmodule

// File: tb/sim_tx_slot_ctrl.sv
module sim_tx_slot_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start, sp, cs, car, done, empty, we, rd;
  logic [1:0] cd;
  logic [1:0] state;
  logic irq, sticky, fclr, txen;

  int vectors = 0;
  int fails = 0;

  logic [1:0] m_st;
  logic m_irq, m_sticky, m_clr;
  string m_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_slot_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_point_i(sp),
    .cs_mode_i(cs), .carrier_i(car), .tx_done_i(done), .fifo_empty_i(empty),
    .ctrl_we_i(we), .ctrl_d_i(cd), .status_rd_i(rd),
    .state_o(state), .done_irq_o(irq), .done_sticky_o(sticky),
    .fifo_clr_o(fclr), .tx_en_o(txen)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model of the requirements
  function automatic void model_step();
    logic sr, ab, act;
    logic [1:0] n;
    logic ev;
    sr = we & cd[0];
    ab = cs & car;
    act = (m_st == 2'd2) || (m_st == 2'd3);
    n = m_st; ev = 1'b0; m_tag = "R2";
    if (sr) begin n = 2'd0; m_tag = "R9"; end
    else if (m_st == 2'd0) begin if (start) n = 2'd1; m_tag = "R2"; end
    else if (ab) begin n = 2'd0; m_tag = (act && done) ? "R10" : "R4"; end
    else if (m_st == 2'd1) begin if (sp) n = 2'd2; m_tag = "R3"; end
    else if (done) begin
      ev = 1'b1;
      n = empty ? 2'd0 : 2'd3;
      m_tag = empty ? "R6" : "R5";
    end
    m_st = n;
    m_irq = ev;
    m_sticky = ev | (m_sticky & ~rd);
    m_clr = we & cd[1];
  endfunction

  task automatic compare();
    chk(m_tag, state, m_st);
    chk("R8 irq", {1'b0, irq}, {1'b0, m_irq});
    chk("R8 sticky", {1'b0, sticky}, {1'b0, m_sticky});
    chk("R7 fifo_clr", {1'b0, fclr}, {1'b0, m_clr});
    chk("R3 tx_en", {1'b0, txen}, {1'b0, m_st[1]});
  endtask

  task automatic cyc(input logic s, input logic p, input logic c, input logic k,
                     input logic d, input logic e, input logic w,
                     input logic [1:0] v, input logic r);
    start = s; sp = p; cs = c; car = k; done = d; empty = e; we = w; cd = v; rd = r;
    model_step();
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h0c0ffee5));
    start = 0; sp = 0; cs = 0; car = 0; done = 0; empty = 1; we = 0; cd = 0; rd = 0;
    m_st = 0; m_irq = 0; m_sticky = 0; m_clr = 0; m_tag = "R1";
    repeat (3) @(negedge clk);
    compare(); // R1 reset state
    rst_n = 1'b1;
    @(negedge clk);
    compare(); // R1 after release

    // R2/R3/R5/R6 main path
    cyc(1,0,0,0,0,1,0,2'b00,0); // idle -> pend
    cyc(1,0,0,0,0,1,0,2'b00,0); // R2 restart stays pending
    cyc(0,0,0,0,1,1,0,2'b00,0); // R6 done in pending ignored
    cyc(0,1,0,0,0,1,0,2'b00,0); // R3 -> prog
    cyc(1,1,0,1,0,0,0,2'b00,0); // R4 carrier without mode ignored
    cyc(0,0,0,0,1,0,0,2'b00,0); // R5 chain
    cyc(0,0,0,0,1,0,0,2'b00,0); // R5 chain again
    cyc(0,0,0,0,1,1,0,2'b00,1); // R6 -> idle, R8 read and set coincide
    cyc(0,0,0,0,0,1,0,2'b00,1); // R8 read clears
    cyc(0,1,0,0,1,1,0,2'b00,0); // R3 strobe in idle ignored
    // R4 abort from pending and in progress
    cyc(1,0,0,0,0,1,0,2'b00,0);
    cyc(0,0,1,1,0,1,0,2'b00,0);
    cyc(1,0,0,0,0,1,0,2'b00,0);
    cyc(0,1,0,0,0,1,0,2'b00,0);
    cyc(0,0,1,1,1,0,0,2'b00,0); // R10 abort beats done
    // R9 soft reset beats done
    cyc(1,0,0,0,0,1,0,2'b00,0);
    cyc(0,1,0,0,0,1,0,2'b00,0);
    cyc(1,1,0,0,1,1,1,2'b01,0); // R9
    cyc(0,0,0,0,0,1,1,2'b10,0); // R7 fifo clear
    cyc(0,0,0,0,0,1,0,2'b00,0); // R7 clear drops
    cyc(1,0,0,0,0,1,1,2'b11,0); // R9 + R7 together

    for (int i = 0; i < 2500; i++) begin
      cyc(($urandom % 4) == 0, ($urandom % 6) == 0, ($urandom % 2) == 0,
          ($urandom % 12) == 0, ($urandom % 5) == 0, ($urandom % 2) == 0,
          ($urandom % 40) == 0, 2'($urandom), ($urandom % 8) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule